// File: doc/BRIEF.md
# Dual-Mode Serial LED Channel Controller

This block is the digital core of a sixteen-channel constant-current LED sink driver. A single serial port (data bit, shift clock and latch strobe) is steered by a mode select to one of two input shift registers. In switch mode it feeds a 16-bit register of per-channel enable bits. In trim mode it feeds a 112-bit register that holds a 7-bit brightness code for each channel. A blank input turns every channel off at once. A cascade output repeats the last bit of whichever shift register is selected, so several devices can be chained on one port.

All serial pins are brought into the core clock domain through two-flop synchronisers before their edges are detected, so shift and latch events happen a fixed number of core cycles after a pin changes. The enable bits move to the channel outputs on a rising latch edge. The trim codes pass through while the latch is high and freeze while it is low. An error output built for an open-drain pad is driven low when the thermal flag is set, or when an enabled, unblanked channel reports an open LED. Both flags are synchronised first.

Top module: `ledSerialCtl`

## Requirements
- R1: Out of reset the channel enables are all 0, every channel's 7-bit code is 7'h7F, the error drive-enable is 0 and the cascade output is 0.
- R2: With the mode select low, each rising shift clock moves the data bit into bit 0 of the 16-bit switch register while the older bits move up one place. The cascade output shows bit 15.
- R3: With the mode select low, a rising latch edge copies the switch register to the channel enables (bit n drives channel n). The enables change only on such an edge or on a change of blank.
- R4: With the mode select high, each rising shift clock moves the data bit into bit 0 of the 112-bit trim register, most significant bit first. Channel n's code sits in bits 7n+6 down to 7n, and the cascade output shows bit 111.
- R5: With the mode select high, the channel codes follow the trim register while the latch is high and keep their value while it is low, even when more bits are shifted in.
- R6: Shifting in one mode leaves the other mode's shift register untouched.
- R7: While blank is high every channel enable is 0. The latched enables return when blank falls, and trim data loads whatever the level of blank.
- R8: A set thermal flag drives the error output. The output is modelled as a drive-enable with a data value of 0, and the drive-enable is 0 when no error is present.
- R9: An open-LED flag drives the error output only when its channel's enable is latched and blank is low.
- R10: The cascade output follows the mode select, switching between bit 15 of the switch register and bit 111 of the trim register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sclkIn | input | 1 | Serial shift clock pin |
| sinIn | input | 1 | Serial data pin |
| latchIn | input | 1 | Latch strobe pin |
| modeIn | input | 1 | 0 selects the switch register, 1 the trim register |
| blankIn | input | 1 | Forces all channels off when high |
| openFlagIn | input | 16 | Per-channel open-LED flags |
| hotFlagIn | input | 1 | Thermal error flag |
| soutOut | output | 1 | Cascade serial output |
| chanEn | output | 16 | Per-channel enable |
| chanCode | output | 112 | Per-channel 7-bit current codes, channel n at [7n+6:7n] |
| errDriveEn | output | 1 | Error pad drive enable |
| errData | output | 1 | Error pad data value, always 0 |

## Verification
The properties assume that the serial pins are slow compared with the core clock. Each level is taken to hold for at least three core cycles. The mode select and data bit are assumed not to change near a shift clock or latch edge, and the mode select does not move while the latch is high. The stimulus meets these assumptions by driving each pin on a falling clock edge and then holding it for four to six core cycles before the next pin moves. Flag inputs are held for six cycles before the error output is sampled.

// File: rtl/ledCtlPkg.sv
package ledCtlPkg;
  typedef struct packed {
    logic shiftOn;
    logic shiftDc;
    logic latchOn;
    logic followDc;
    logic modeDc;
    logic blankS;
    logic serialBit;
  } ctlStrobes_t;
endpackage

// File: rtl/ledCtlControl.sv
module ledCtlControl
  import ledCtlPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sclkIn,
  input  logic        sinIn,
  input  logic        latchIn,
  input  logic        modeIn,
  input  logic        blankIn,
  output ctlStrobes_t strobes
);
  localparam int PINS = 5;

  logic [PINS-1:0] syncChain [SYNC_STAGES];
  logic [PINS-1:0] pinsS;
  logic            sclkPrev;
  logic            latchPrev;

  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : gSync
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncChain[g] <= '0;
        else if (g == 0) syncChain[g] <= {sinIn, blankIn, modeIn, latchIn, sclkIn};
        else syncChain[g] <= syncChain[g-1];
      end
    end
  endgenerate

  assign pinsS = syncChain[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkPrev  <= 1'b0;
      latchPrev <= 1'b0;
    end else begin
      sclkPrev  <= pinsS[0];
      latchPrev <= pinsS[1];
    end
  end

  always_comb begin
    strobes.modeDc    = pinsS[2];
    strobes.blankS    = pinsS[3];
    strobes.serialBit = pinsS[4];
    strobes.shiftOn   = pinsS[0] & ~sclkPrev & ~pinsS[2];
    strobes.shiftDc   = pinsS[0] & ~sclkPrev & pinsS[2];
    strobes.latchOn   = pinsS[1] & ~latchPrev & ~pinsS[2];
    strobes.followDc  = pinsS[1] & pinsS[2];
  end
endmodule

// File: rtl/ledCtlDatapath.sv
module ledCtlDatapath
  import ledCtlPkg::*;
#(
  parameter int CHANNELS = 16,
  parameter int CODE_W   = 7
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  ctlStrobes_t                  strobes,
  input  logic                         blankIn,
  input  logic [CHANNELS-1:0]          openFlagIn,
  input  logic                         hotFlagIn,
  output logic                         soutOut,
  output logic [CHANNELS-1:0]          chanEn,
  output logic [CHANNELS*CODE_W-1:0]   chanCode,
  output logic                         errDriveEn,
  output logic                         errData
);
  localparam int DC_W = CHANNELS * CODE_W;

  logic [CHANNELS-1:0] onShift;
  logic [CHANNELS-1:0] onLatch;
  logic [DC_W-1:0]     dcShift;
  logic [DC_W-1:0]     dcLatch;
  logic [CHANNELS-1:0] openMeta;
  logic [CHANNELS-1:0] openSync;
  logic                hotMeta;
  logic                hotSync;
  logic [CHANNELS-1:0] openLive;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      onShift <= '0;
      dcShift <= '0;
    end else begin
      if (strobes.shiftOn) onShift <= {onShift[CHANNELS-2:0], strobes.serialBit};
      if (strobes.shiftDc) dcShift <= {dcShift[DC_W-2:0], strobes.serialBit};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      onLatch <= '0;
      dcLatch <= {CHANNELS{{CODE_W{1'b1}}}};
    end else begin
      if (strobes.latchOn)  onLatch <= onShift;
      if (strobes.followDc) dcLatch <= dcShift;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      openMeta <= '0;
      openSync <= '0;
      hotMeta  <= 1'b0;
      hotSync  <= 1'b0;
    end else begin
      openMeta <= openFlagIn;
      openSync <= openMeta;
      hotMeta  <= hotFlagIn;
      hotSync  <= hotMeta;
    end
  end

  genvar ch;
  generate
    for (ch = 0; ch < CHANNELS; ch++) begin : gChan
      assign openLive[ch] = openSync[ch] & onLatch[ch] & ~strobes.blankS;
      assign chanEn[ch]   = onLatch[ch] & ~blankIn;
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) errDriveEn <= 1'b0;
    else       errDriveEn <= hotSync | (|openLive);
  end

  assign errData  = 1'b0;
  assign chanCode = dcLatch;
  assign soutOut  = strobes.modeDc ? dcShift[DC_W-1] : onShift[CHANNELS-1];
endmodule

// File: rtl/ledSerialCtl.sv
module ledSerialCtl
  import ledCtlPkg::*;
#(
  parameter int CHANNELS = 16,
  parameter int CODE_W   = 7
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       sclkIn,
  input  logic                       sinIn,
  input  logic                       latchIn,
  input  logic                       modeIn,
  input  logic                       blankIn,
  input  logic [CHANNELS-1:0]        openFlagIn,
  input  logic                       hotFlagIn,
  output logic                       soutOut,
  output logic [CHANNELS-1:0]        chanEn,
  output logic [CHANNELS*CODE_W-1:0] chanCode,
  output logic                       errDriveEn,
  output logic                       errData
);
  ctlStrobes_t strobes;

  ledCtlControl #(.SYNC_STAGES(2)) control (
    .clk(clk), .rstN(rstN), .sclkIn(sclkIn), .sinIn(sinIn),
    .latchIn(latchIn), .modeIn(modeIn), .blankIn(blankIn),
    .strobes(strobes)
  );

  ledCtlDatapath #(.CHANNELS(CHANNELS), .CODE_W(CODE_W)) datapath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .blankIn(blankIn),
    .openFlagIn(openFlagIn), .hotFlagIn(hotFlagIn), .soutOut(soutOut),
    .chanEn(chanEn), .chanCode(chanCode), .errDriveEn(errDriveEn),
    .errData(errData)
  );
endmodule

// File: rtl/ledCtlChecker.sv
module ledCtlChecker #(
  parameter int CHANNELS = 16,
  parameter int CODE_W   = 7
) (
  input logic                       clk,
  input logic                       rstN,
  input logic                       latchIn,
  input logic                       blankIn,
  input logic                       hotFlagIn,
  input logic [CHANNELS-1:0]        chanEn,
  input logic [CHANNELS*CODE_W-1:0] chanCode,
  input logic                       errDriveEn
);
  logic [2:0] sinceRst;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sinceRst <= '0;
    else if (sinceRst != 3'd7) sinceRst <= sinceRst + 3'd1;
  end

  // R7: blank forces every enable off
  assert_blank_off_R7: assert property (@(posedge clk) disable iff (!rstN)
    blankIn |-> (chanEn == '0));

  // R3: enables move only after a latch edge or a blank change
  assert_en_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst >= 3'd4) && !blankIn && !$past(blankIn) && !$past(latchIn, 3)
      |-> $stable(chanEn));

  // R5: codes hold while the latch has been low
  assert_code_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst >= 3'd4) && !$past(latchIn, 3) |-> $stable(chanCode));

  // R8: a thermal flag reaches the error pad after synchronisation
  assert_hot_err_R8: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst >= 3'd4) && $past(hotFlagIn, 3) |-> errDriveEn);
endmodule

bind ledSerialCtl ledCtlChecker #(.CHANNELS(CHANNELS), .CODE_W(CODE_W)) chk (
  .clk(clk), .rstN(rstN), .latchIn(latchIn), .blankIn(blankIn),
  .hotFlagIn(hotFlagIn), .chanEn(chanEn), .chanCode(chanCode),
  .errDriveEn(errDriveEn)
);

// File: tb/ledSerialCtl_test.sv
`timescale 1ns/1ps
module ledSerialCtl_test;
  localparam int CH = 16;
  localparam int CW = 7;
  localparam int DW = CH * CW;

  typedef struct {
    logic [CH-1:0] en;
    logic [DW-1:0] code;
    logic          err;
    logic          sout;
    string         tag;
  } expItem_t;

  logic clk = 0;
  logic rstN = 0;
  logic sclkIn = 0, sinIn = 0, latchIn = 0, modeIn = 0, blankIn = 0, hotFlagIn = 0;
  logic [CH-1:0] openFlagIn = '0;
  logic soutOut, errDriveEn, errData;
  logic [CH-1:0] chanEn;
  logic [DW-1:0] chanCode;

  int errors = 0;
  int checks = 0;
  bit finished = 0;
  expItem_t q[$];

  logic [CH-1:0] onShiftM = '0, onLatchM = '0;
  logic [DW-1:0] dcShiftM = '0, dcLatchM = {CH{7'h7F}};

  always #2 clk = ~clk;

  ledSerialCtl uut (
    .clk(clk), .rstN(rstN), .sclkIn(sclkIn), .sinIn(sinIn), .latchIn(latchIn),
    .modeIn(modeIn), .blankIn(blankIn), .openFlagIn(openFlagIn),
    .hotFlagIn(hotFlagIn), .soutOut(soutOut), .chanEn(chanEn),
    .chanCode(chanCode), .errDriveEn(errDriveEn), .errData(errData)
  );

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expectNow(input string tag);
    expItem_t it;
    it.en   = blankIn ? '0 : onLatchM;
    it.code = dcLatchM;
    it.err  = hotFlagIn | (|(openFlagIn & onLatchM & {CH{~blankIn}}));
    it.sout = modeIn ? dcShiftM[DW-1] : onShiftM[CH-1];
    it.tag  = tag;
    q.push_back(it);
    wait (q.size() == 0);
    waitClk(1);
  endtask

  task automatic sendBit(input logic b);
    sinIn = b;
    waitClk(4);
    sclkIn = 1;
    waitClk(4);
    sclkIn = 0;
    waitClk(4);
    if (modeIn) dcShiftM = {dcShiftM[DW-2:0], b};
    else        onShiftM = {onShiftM[CH-2:0], b};
  endtask

  task automatic pulseLatch();
    latchIn = 1;
    waitClk(6);
    latchIn = 0;
    waitClk(6);
    if (modeIn) dcLatchM = dcShiftM;
    else        onLatchM = onShiftM;
  endtask

  task automatic setMode(input logic m);
    modeIn = m;
    waitClk(5);
  endtask

  // monitor: pops expected items and compares at a falling edge
  initial begin
    expItem_t it;
    forever begin
      wait (q.size() != 0);
      @(negedge clk);
      it = q[0];
      checks += 5;
      if (chanEn !== it.en) begin
        errors++; $display("FAIL %s enables: actual %h expected %h", it.tag, chanEn, it.en);
      end
      if (chanCode !== it.code) begin
        errors++; $display("FAIL %s codes: actual %h expected %h", it.tag, chanCode, it.code);
      end
      if (errDriveEn !== it.err) begin
        errors++; $display("FAIL %s error drive: actual %b expected %b", it.tag, errDriveEn, it.err);
      end
      if (soutOut !== it.sout) begin
        errors++; $display("FAIL %s cascade: actual %b expected %b", it.tag, soutOut, it.sout);
      end
      if (errData !== 1'b0) begin
        errors++; $display("FAIL R8 error data: actual %b expected 0", errData);
      end
      void'(q.pop_front());
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] patA = 16'hA5C3;
    logic [15:0] patB = 16'h00F0;
    logic [6:0]  c;
    waitClk(4);
    rstN = 1;
    waitClk(3);
    expectNow("R1 reset state");

    // R2: shift switch pattern, not yet latched
    for (int i = CH - 1; i >= 0; i--) sendBit(patA[i]);
    expectNow("R2 switch shift before latch");
    pulseLatch();
    expectNow("R3 enables after latch edge");

    // R4: trim data, channel n code = 9n+5, MSB first from channel 15
    setMode(1);
    for (int n = CH - 1; n >= 0; n--) begin
      c = 7'((n * 9 + 5) & 7'h7F);
      for (int b = CW - 1; b >= 0; b--) sendBit(c[b]);
    end
    expectNow("R4 R10 trim shift, codes held R5");
    setMode(0);
    expectNow("R6 R10 switch register kept");
    setMode(1);
    pulseLatch();
    expectNow("R5 codes follow latch");
    for (int i = 0; i < CW; i++) sendBit(i[0]);
    expectNow("R5 codes hold with latch low");

    // R7 blank behaviour with a new switch pattern
    setMode(0);
    for (int i = CH - 1; i >= 0; i--) sendBit(patB[i]);
    pulseLatch();
    expectNow("R3 second pattern");
    blankIn = 1; waitClk(5);
    expectNow("R7 blank high");
    blankIn = 0; waitClk(5);
    expectNow("R7 blank released");

    // R8 thermal flag
    hotFlagIn = 1; waitClk(6);
    expectNow("R8 thermal set");
    hotFlagIn = 0; waitClk(6);
    expectNow("R8 thermal clear");

    // R9 open flags
    openFlagIn = 16'h0010; waitClk(6);
    expectNow("R9 open on enabled channel");
    openFlagIn = 16'h0001; waitClk(6);
    expectNow("R9 open on disabled channel");
    openFlagIn = 16'h0010; blankIn = 1; waitClk(6);
    expectNow("R9 open while blanked");
    openFlagIn = '0; blankIn = 0; waitClk(6);
    expectNow("R9 flags clear");

    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule